// File: doc/BRIEF.md
# H-Bridge Leg Sequencer with Fault Latch

This block is the clocked control core of a full bridge made of two half-bridge legs, A and B. It takes the direction bits, a PWM bit, the two enable/diagnostic lines, a sense-disable bit, per-leg digitised fault flags and digitised supply-window flags. From these it produces four gate enables, a strobe that allows the current sense path, a pull-low request for each enable/diagnostic line and a standby flag. Analog current limiting, temperature measurement, gate drivers and the charge pump are outside it.

All asynchronous inputs pass through two-flop synchronisers. A per-leg state (off, drive high, drive low) is computed from the synchronised inputs. Any change of that pair of states passes through a blanking interval of `DELAY_CYC` clock cycles, during which all four gates are off, before the new switches are turned on. PWM gates the low sides directly, without blanking. A fault on a leg latches that leg off and requests its diagnostic line low until the leg's direction input rises again.

Top module: `hbridge_ctrl`

## Requirements
- R1: While `rst_n` is low all gate enables, both pull-low requests and the sense strobe are 0; with all synchronised inputs at 0, `standby_o` reads 1.
- R2: With both legs running and the blanking finished, direction bits (A,B) map as: 1,0 gives HS A and LS B on; 0,1 gives LS A and HS B on; 1,1 gives both high sides on; 0,0 gives both low sides on.
- R3: A synchronised PWM value of 0 turns both low-side enables off within the next cycle, whatever the mode; a return to 1 restores them with no blanking interval.
- R4: A low level on a leg's enable input turns both of that leg's gates off; the other leg keeps following its direction bit.
- R5: A high-side overtemperature flag or a low-side overload flag on a leg sets that leg's fault latch; a latched leg has both gates off and its pull-low request at 1.
- R6: A latched fault clears only on a low-to-high change of that leg's synchronised direction bit while both of its fault flags are 0; a falling direction edge, or a rising edge while a flag is still 1, leaves it set.
- R7: Whenever the per-leg state pair changes, all four gates are off from the cycle after the synchronised change for `DELAY_CYC` cycles; a further change restarts the interval.
- R8: `sense_en_o` is 1 only when the applied mode is one leg high and the other low, the blanking interval is over and `sense_off_i` is 0.
- R9: `standby_o` is 1 exactly when both direction bits, PWM and both enable inputs are low (synchronised) and neither leg holds a latched fault.
- R10: An undervoltage or overvoltage flag treats both legs as off, so all gates are off after the blanking starts and stay off while the flag is set.
- R11: Within a leg the high-side and low-side enables are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_a_i | input | 1 | Direction bit for leg A (1 = drive high) |
| dir_b_i | input | 1 | Direction bit for leg B (1 = drive high) |
| pwm_i | input | 1 | PWM bit; 0 turns both low sides off |
| en_a_i | input | 1 | Sensed level of leg A enable/diagnostic line |
| en_b_i | input | 1 | Sensed level of leg B enable/diagnostic line |
| sense_off_i | input | 1 | 1 disables the current sense strobe |
| hs_hot_a_i | input | 1 | Leg A high-side overtemperature flag |
| ls_ovl_a_i | input | 1 | Leg A low-side overload/saturation flag |
| hs_hot_b_i | input | 1 | Leg B high-side overtemperature flag |
| ls_ovl_b_i | input | 1 | Leg B low-side overload/saturation flag |
| uv_i | input | 1 | Supply below undervoltage threshold |
| ov_i | input | 1 | Supply above overvoltage threshold |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |
| diag_a_pull_o | output | 1 | Request to pull leg A enable/diagnostic line low |
| diag_b_pull_o | output | 1 | Request to pull leg B enable/diagnostic line low |
| sense_en_o | output | 1 | Current sense path enable |
| standby_o | output | 1 | Standby condition reached |

## Verification
The timed properties assume each input reaches the logic exactly two clock edges after it is sampled at the port, so they reach back at most four cycles and are gated off for the first cycles after reset, when the synchronisers still hold their reset values. They also assume fault flags and direction bits are plain levels that stay put for at least one synchronised cycle. The stimulus respects this by changing inputs only at falling clock edges and holding every level for several cycles, fault flags for three cycles or more, and it waits out the full blanking interval before judging a new mode.

// File: rtl/hb_pkg.sv
// Shared types and helpers for the bridge controller.
// Assumes: two legs, each either off, driven high or driven low.
package hb_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_st_t;

    typedef struct packed {
        leg_st_t a;
        leg_st_t b;
    } bridge_mode_t;

    localparam bridge_mode_t MODE_IDLE = '{a: LEG_OFF, b: LEG_OFF};

    // Per-leg state from its run permission and direction bit.
    function automatic leg_st_t leg_state(input logic run, input logic dir);
        if (!run)
            return LEG_OFF;
        return dir ? LEG_HIGH : LEG_LOW;
    endfunction

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchroniser for a bundle of independent asynchronous bits.
// Assumes: each bit is a level held longer than STAGES cycles; no bus coherency.
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++)
                stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_leg_fault.sv
// Fault latch for one bridge leg.
// Sets on either fault flag; clears only on a rising edge of the leg's
// direction bit while no flag is present (set has priority).
// Assumes: all inputs are already synchronised to clk.
module hb_leg_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    input  logic hot_i,
    input  logic ovl_i,
    output logic fault_o
);
    logic dir_prev_q;
    logic fault_q;

    // Remember the previous direction level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_prev_q <= 1'b0;
        else        dir_prev_q <= dir_i;
    end

    // Latch on fault, release on a rising direction edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (hot_i || ovl_i)
            fault_q <= 1'b1;
        else if (dir_i && !dir_prev_q)
            fault_q <= 1'b0;
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/hb_mode_seq.sv
// Mode sequencer: holds the applied bridge mode and blanks the gates for
// DELAY_CYC cycles whenever the requested mode differs from it.
// A request that changes during blanking restarts the count.
// Assumes: DELAY_CYC >= 2; tgt_i comes from registered logic.
module hb_mode_seq
    import hb_pkg::*;
#(
    parameter int DELAY_CYC = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bridge_mode_t tgt_i,
    output bridge_mode_t applied_o,
    output logic         busy_o
);
    localparam int CNT_W = $clog2(DELAY_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    bridge_mode_t tgt_q;
    bridge_mode_t applied_q;
    logic [CNT_W-1:0] cnt_q;

    // Track the request, count stable blanking cycles, then apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q     <= MODE_IDLE;
            applied_q <= MODE_IDLE;
            cnt_q     <= '0;
        end else begin
            tgt_q <= tgt_i;
            if (tgt_i != tgt_q) begin
                cnt_q <= '0;
            end else if (tgt_q != applied_q) begin
                if (cnt_q == LAST) begin
                    applied_q <= tgt_q;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign applied_o = applied_q;
    assign busy_o    = (tgt_q != applied_q);
endmodule

// File: rtl/hbridge_ctrl.sv
// Top of the H-bridge controller.
// Synchronises all inputs, latches per-leg faults, derives the requested
// mode, sequences it through a blanking interval and decodes the gates.
// Assumes: fault and supply flags are digitised levels; the enable inputs
// reflect the external line level, the pull outputs drive it low.
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DELAY_CYC   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic pwm_i,
    input  logic en_a_i,
    input  logic en_b_i,
    input  logic sense_off_i,
    input  logic hs_hot_a_i,
    input  logic ls_ovl_a_i,
    input  logic hs_hot_b_i,
    input  logic ls_ovl_b_i,
    input  logic uv_i,
    input  logic ov_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o,
    output logic diag_a_pull_o,
    output logic diag_b_pull_o,
    output logic sense_en_o,
    output logic standby_o
);
    localparam int NUM_LEGS = 2;
    localparam int NUM_IN   = 12;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;

    logic s_pwm, s_sense_off, s_uv, s_ov;
    logic [NUM_LEGS-1:0] s_dir, s_en, s_hot, s_ovl, fault;
    logic supply_ok;

    bridge_mode_t tgt, applied;
    logic busy;

    assign raw_in = {ov_i, uv_i, sense_off_i, pwm_i,
                     ls_ovl_b_i, hs_hot_b_i, en_b_i, dir_b_i,
                     ls_ovl_a_i, hs_hot_a_i, en_a_i, dir_a_i};

    hb_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign s_dir       = {syn_in[4], syn_in[0]};
    assign s_en        = {syn_in[5], syn_in[1]};
    assign s_hot       = {syn_in[6], syn_in[2]};
    assign s_ovl       = {syn_in[7], syn_in[3]};
    assign s_pwm       = syn_in[8];
    assign s_sense_off = syn_in[9];
    assign s_uv        = syn_in[10];
    assign s_ov        = syn_in[11];
    assign supply_ok   = !s_uv && !s_ov;

    // One fault latch per leg.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg_fault u_fault (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_i   (s_dir[g]),
            .hot_i   (s_hot[g]),
            .ovl_i   (s_ovl[g]),
            .fault_o (fault[g])
        );
    end

    // Requested mode from supply window, enables, faults and directions.
    always_comb begin
        tgt.a = leg_state(supply_ok && s_en[0] && !fault[0], s_dir[0]);
        tgt.b = leg_state(supply_ok && s_en[1] && !fault[1], s_dir[1]);
    end

    hb_mode_seq #(.DELAY_CYC(DELAY_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_i     (tgt),
        .applied_o (applied),
        .busy_o    (busy)
    );

    // Gate decode: blanked while busy, low sides gated by PWM.
    always_comb begin
        hs_a_o = !busy && (applied.a == LEG_HIGH);
        ls_a_o = !busy && (applied.a == LEG_LOW) && s_pwm;
        hs_b_o = !busy && (applied.b == LEG_HIGH);
        ls_b_o = !busy && (applied.b == LEG_LOW) && s_pwm;
    end

    // Sense strobe only in the two running directions.
    always_comb begin
        sense_en_o = !busy && !s_sense_off &&
                     (((applied.a == LEG_HIGH) && (applied.b == LEG_LOW)) ||
                      ((applied.a == LEG_LOW)  && (applied.b == LEG_HIGH)));
    end

    assign diag_a_pull_o = fault[0];
    assign diag_b_pull_o = fault[1];
    assign standby_o     = (s_dir == '0) && (s_en == '0) && !s_pwm && (fault == '0);
endmodule

// File: rtl/hb_ctrl_chk.sv
// Property checker for hbridge_ctrl, attached by bind.
// Assumes: two synchroniser stages, so port inputs act two edges later.
module hb_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dir_a_i,
    input logic pwm_i,
    input logic hs_hot_a_i,
    input logic ls_ovl_a_i,
    input logic hs_hot_b_i,
    input logic ls_ovl_b_i,
    input logic uv_i,
    input logic ov_i,
    input logic hs_a_o,
    input logic ls_a_o,
    input logic hs_b_o,
    input logic ls_b_o,
    input logic diag_a_pull_o,
    input logic diag_b_pull_o,
    input logic sense_en_o
);
    logic [2:0] since_rst_q;
    logic       warm;

    // Count cycles since reset so history checks skip the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
    end
    assign warm = (since_rst_q >= 3'd5);

    a_r11_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o));
    a_r11_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o));
    a_r3_pwm_low_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(pwm_i, 2)) |-> (!ls_a_o && !ls_b_o));
    a_r5_fault_a_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hs_hot_a_i || ls_ovl_a_i, 2)) |=> diag_a_pull_o);
    a_r5_fault_b_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(hs_hot_b_i || ls_ovl_b_i, 2)) |=> diag_b_pull_o);
    a_r6_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $fell(diag_a_pull_o)) |-> ($past(dir_a_i, 3) && !$past(dir_a_i, 4)));
    a_r7_hs_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(hs_a_o)) |-> $past(!hs_b_o && !ls_a_o && !ls_b_o));
    a_r10_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(uv_i || ov_i, 2)) |=> (!hs_a_o && !ls_a_o && !hs_b_o && !ls_b_o));
    a_r8_sense_running: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en_o |-> (hs_a_o != hs_b_o));
endmodule

bind hbridge_ctrl hb_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_a_i       (dir_a_i),
    .pwm_i         (pwm_i),
    .hs_hot_a_i    (hs_hot_a_i),
    .ls_ovl_a_i    (ls_ovl_a_i),
    .hs_hot_b_i    (hs_hot_b_i),
    .ls_ovl_b_i    (ls_ovl_b_i),
    .uv_i          (uv_i),
    .ov_i          (ov_i),
    .hs_a_o        (hs_a_o),
    .ls_a_o        (ls_a_o),
    .hs_b_o        (hs_b_o),
    .ls_b_o        (ls_b_o),
    .diag_a_pull_o (diag_a_pull_o),
    .diag_b_pull_o (diag_b_pull_o),
    .sense_en_o    (sense_en_o)
);

// File: tb/tb_hbridge_ctrl.sv
// Scoreboard bench: the driver queues expected output vectors, the monitor
// pops and compares them on falling edges.
// Vector order: {hs_a, ls_a, hs_b, ls_b, pull_a, pull_b, sense, standby}.
module tb_hbridge_ctrl;
    localparam int DLY  = 16;
    localparam int WAIT = DLY + 6;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_a = 0, dir_b = 0, pwm = 0, en_a = 0, en_b = 0, soff = 0;
    logic hot_a = 0, ovl_a = 0, hot_b = 0, ovl_b = 0, uv = 0, ov = 0;
    logic hs_a, ls_a, hs_b, ls_b, pull_a, pull_b, sense, stby;

    int n_checks = 0;
    int n_fail   = 0;
    int excl_bad = 0;
    bit done     = 0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    hbridge_ctrl #(.DELAY_CYC(DLY), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .dir_a_i(dir_a), .dir_b_i(dir_b), .pwm_i(pwm),
        .en_a_i(en_a), .en_b_i(en_b), .sense_off_i(soff),
        .hs_hot_a_i(hot_a), .ls_ovl_a_i(ovl_a),
        .hs_hot_b_i(hot_b), .ls_ovl_b_i(ovl_b),
        .uv_i(uv), .ov_i(ov),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
        .diag_a_pull_o(pull_a), .diag_b_pull_o(pull_b),
        .sense_en_o(sense), .standby_o(stby)
    );

    // Monitor: compare queued expectations; watch leg exclusivity (R11).
    always @(negedge clk) begin
        if (hs_a && ls_a || hs_b && ls_b) excl_bad++;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if ({hs_a, ls_a, hs_b, ls_b, pull_a, pull_b, sense, stby} !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", it.tag,
                         {hs_a, ls_a, hs_b, ls_b, pull_a, pull_b, sense, stby}, it.exp);
            end
        end
    end

    // Driver helper: wait n rising edges, then queue an expectation.
    task automatic expect_after(input int n, input logic [7:0] exp, input string tag);
        repeat (n) @(posedge clk);
        #1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        n_checks++;
        if (excl_bad != 0) begin
            n_fail++;
            $display("FAIL R11: actual %0d overlap cycles expected 0", excl_bad);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        expect_after(1, 8'b0000_0001, "R1 reset state");
        rst_n = 1'b1;
        expect_after(3, 8'b0000_0001, "R9 standby after reset");

        // Clockwise start.
        en_a = 1; en_b = 1; pwm = 1; dir_a = 1; dir_b = 0;
        expect_after(3, 8'b0000_0000, "R7 blank on first mode");
        expect_after(WAIT - 3, 8'b1001_0010, "R2 clockwise");

        dir_a = 0; dir_b = 1;
        expect_after(3, 8'b0000_0000, "R7 blank on reversal");
        expect_after(WAIT - 3, 8'b0110_0010, "R2 counter-clockwise");

        pwm = 0;
        expect_after(3, 8'b0010_0010, "R3 pwm low drops low side");
        pwm = 1;
        expect_after(3, 8'b0110_0010, "R3 pwm high restores low side");

        dir_a = 1; dir_b = 1;
        expect_after(WAIT, 8'b1010_0000, "R2 R8 brake high no sense");
        dir_a = 0; dir_b = 0;
        expect_after(WAIT, 8'b0101_0000, "R2 R8 brake low no sense");
        pwm = 0;
        expect_after(3, 8'b0000_0000, "R3 pwm low in brake low");
        pwm = 1;
        expect_after(3, 8'b0101_0000, "R3 pwm restore in brake low");

        dir_a = 1;
        expect_after(WAIT, 8'b1001_0010, "R2 clockwise again");
        soff = 1;
        expect_after(3, 8'b1001_0000, "R8 sense disabled");
        soff = 0;
        expect_after(3, 8'b1001_0010, "R8 sense re-enabled");

        en_a = 0;
        expect_after(WAIT, 8'b0001_0000, "R4 leg A disabled");
        en_a = 1;
        expect_after(WAIT, 8'b1001_0010, "R4 leg A re-enabled");

        // Leg A overtemperature.
        hot_a = 1;
        expect_after(4, 8'b0000_1000, "R5 fault A latched gates off");
        hot_a = 0;
        expect_after(WAIT, 8'b0001_1000, "R5 fault A holds leg off");
        dir_a = 0;
        expect_after(WAIT, 8'b0001_1000, "R6 falling edge keeps fault");
        dir_a = 1;
        expect_after(WAIT, 8'b1001_0010, "R6 rising edge clears fault");

        // Leg B overload, clear attempt while flag still present.
        ovl_b = 1;
        expect_after(WAIT, 8'b1000_0100, "R5 fault B latched");
        dir_b = 1;
        expect_after(WAIT, 8'b1000_0100, "R6 rise with flag present keeps fault");
        ovl_b = 0; dir_b = 0;
        expect_after(WAIT, 8'b1000_0100, "R6 fault B still latched");
        dir_b = 1;
        expect_after(WAIT, 8'b1010_0000, "R6 fault B cleared");

        // Supply window.
        uv = 1;
        expect_after(WAIT, 8'b0000_0000, "R10 undervoltage off");
        uv = 0;
        expect_after(WAIT, 8'b1010_0000, "R10 undervoltage recovered");
        ov = 1;
        expect_after(WAIT, 8'b0000_0000, "R10 overvoltage off");
        ov = 0;
        expect_after(WAIT, 8'b1010_0000, "R10 overvoltage recovered");

        // Standby entry and blocking by a latched fault.
        dir_a = 0; dir_b = 0; pwm = 0; en_a = 0; en_b = 0;
        expect_after(WAIT, 8'b0000_0001, "R9 standby entered");
        hot_a = 1;
        repeat (3) @(posedge clk);
        #1 hot_a = 0;
        expect_after(WAIT, 8'b0000_1000, "R9 fault blocks standby");
        dir_a = 1;
        repeat (6) @(posedge clk);
        #1 dir_a = 0;
        expect_after(WAIT, 8'b0000_0001, "R9 R6 standby after clear");

        repeat (3) @(posedge clk);
        done = 1;
        finish_run();
    end
endmodule